// File: doc/BRIEF.md
# Touch Conversion Scheduler

This block decides when a touch-panel controller starts an analog conversion, and it tracks which result channels hold data that has not yet been read. Software programs one control word. That word carries an enable, a scan function code and a resolution code. The block starts a conversion when the function permits one, the pen state permits one and no unread data is pending. A conversion lasts a fixed number of clock cycles, derived from the clock frequency and a nominal rate of 1024 conversions per second. When it finishes, the block ORs a function-specific bit mask into a 16-bit data-available register and pulls an active-low data-ready interrupt.

Each bit of the data-available register is cleared by its own read strobe. A separately selected pen-interrupt function drives an active-low pen interrupt from the pen pressure and the pending data. Some functions are single-shot: once their data is pending, they switch the block off. The block also shifts a 16-bit raw result, supplied on a port, down to the resolution that was latched when the last conversion started.

Top module: `touch_conv_sched`

## Requirements
- R1: After reset, the block is disabled and not busy. The data-available register is 0, both interrupt outputs are high, the next function and resolution codes are 0, and the pen-interrupt function code is 2.
- R2: A write to the control word sets the enable from bit 14 (1 = disabled), the next function from bits 13:10 and the next resolution from bits 9:8. Bit 15 and bits 7:0 are accepted and have no effect.
- R3: A conversion starts in the same cycle as the write (or state) that allows it, and only under all of these conditions: the block is enabled, it is not busy and the data-available register is zero. Function codes 1 to 5 also need `pen_down` high. Codes 0 and 13 to 15 never start a conversion, and codes 6 to 12 need no pen. The next function and resolution are latched as the active ones when the conversion starts.
- R4: `busy` stays high for exactly CLK_HZ/CONV_RATE_HZ cycles. When it falls, the function's mask is ORed into the data-available register and `dav_irq_n` goes low in the same cycle.
- R5: The completion masks, by function code, are: 1→0x0600, 2→0x0780, 3→0x0400, 4→0x0200, 5→0x0180, 6→0x0040, 7→0x0030, 8→0x0010, 9→0x0010, 10→0x0004, 11→0x0070, 12→0x0002.
- R6: A high bit k of `rd_strobe` clears data-available bit k only. Strobes on bits that are clear have no effect. `dav_irq_n` returns high in the cycle the register becomes zero.
- R7: Function codes 6, 7, 8, 10 and 12 clear the enable while any data-available bit is set. Codes 3, 4 and 5 do the same, but only while `pen_down` is high. With codes 1, 2, 9 and 11 the block stays enabled, so clearing the data restarts a conversion.
- R8: A control write that disables the block while it is busy clears `busy` at that edge, and that conversion never sets any data-available bit.
- R9: Writing `pen_fn_sel` selects the pen-interrupt function: 0 gives pressure, 1 gives any data available, and 2 or 3 gives pressure with no data available. `pen_irq_n` is the registered inverse of the selected term, one cycle behind, and it is forced high while the block is disabled.
- R10: `result_out` is `raw_in` shifted right by 4, 8, 6 or 4 bits for active resolution codes 0, 1, 2 and 3 (12, 8, 10 and 12 bits). Changing the next resolution without starting a conversion does not change the shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 16 | Control word: disable, next function, next resolution |
| pen_fn_we | input | 1 | Pen-interrupt function select write strobe |
| pen_fn_sel | input | 2 | Pen-interrupt function code |
| pen_down | input | 1 | Pen pressure present |
| rd_strobe | input | 16 | Per-channel result read strobes, one per data-available bit |
| raw_in | input | 16 | Raw 16-bit conversion value |
| busy | output | 1 | Conversion in progress |
| dav_flags | output | 16 | Data-available register |
| result_out | output | 16 | Raw value truncated to the active resolution |
| pen_irq_n | output | 1 | Pen interrupt, active low |
| dav_irq_n | output | 1 | Data-ready interrupt, active low |

## Verification
The checker module covers the invariants that hold on every cycle:
- no conversion runs or starts while data is pending;
- no data bit appears except at the end of a conversion, and the data-ready interrupt only falls as `busy` ends;
- a strobe taken while idle clears its bit;
- a disabling write stops `busy`;
- a disabled block keeps the pen interrupt high.

The bench scenarios cover the rest, which depends on the function code:
- the exact mask for each of the sixteen codes, with and without pen pressure;
- the conversion length;
- which codes disable the block and which restart it;
- the pen-interrupt truth table for every code;
- the truncation that follows the resolution latched at start.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
  localparam int DATA_W = 16;
  localparam int FN_W   = 4;
  localparam int RES_W  = 2;

  typedef enum logic [1:0] {
    PIN_PRESS       = 2'd0,
    PIN_ANY_DATA    = 2'd1,
    PIN_PRESS_CLEAR = 2'd2,
    PIN_PRESS_ALT   = 2'd3
  } pin_fn_e;

  function automatic logic [DATA_W-1:0] done_mask(input logic [FN_W-1:0] f);
    case (f)
      4'd1:    done_mask = 16'h0600;
      4'd2:    done_mask = 16'h0780;
      4'd3:    done_mask = 16'h0400;
      4'd4:    done_mask = 16'h0200;
      4'd5:    done_mask = 16'h0180;
      4'd6:    done_mask = 16'h0040;
      4'd7:    done_mask = 16'h0030;
      4'd8,
      4'd9:    done_mask = 16'h0010;
      4'd10:   done_mask = 16'h0004;
      4'd11:   done_mask = 16'h0070;
      4'd12:   done_mask = 16'h0002;
      default: done_mask = 16'h0000;
    endcase
  endfunction

  function automatic logic [3:0] trunc_shift(input logic [RES_W-1:0] r);
    case (r)
      2'd1:    trunc_shift = 4'd8;
      2'd2:    trunc_shift = 4'd6;
      default: trunc_shift = 4'd4;
    endcase
  endfunction

  function automatic logic wants_pen(input logic [FN_W-1:0] f);
    wants_pen = (f >= 4'd1) && (f <= 4'd5);
  endfunction

  function automatic logic idle_fn(input logic [FN_W-1:0] f);
    idle_fn = (f == 4'd0) || (f >= 4'd13);
  endfunction

  function automatic logic one_shot(input logic [FN_W-1:0] f);
    one_shot = ((f >= 4'd3) && (f <= 4'd8)) || (f == 4'd10) || (f == 4'd12);
  endfunction
endpackage

// File: rtl/tcs_ctrl_regs.sv
module tcs_ctrl_regs
  import tcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              kill,
  output logic              en_q,
  output logic              en_v,
  output logic [FN_W-1:0]   nf_v,
  output logic [RES_W-1:0]  nr_v
);
  logic              en_n;
  logic [FN_W-1:0]   nf_q;
  logic [RES_W-1:0]  nr_q;

  always_comb begin
    en_v = we ? ~wdata[14]    : en_q;
    nf_v = we ? wdata[13:10]  : nf_q;
    nr_v = we ? wdata[9:8]    : nr_q;
    en_n = en_v & ~kill;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      nf_q <= '0;
      nr_q <= '0;
    end else begin
      en_q <= en_n;
      nf_q <= nf_v;
      nr_q <= nr_v;
    end
  end
endmodule

// File: rtl/tcs_conv_timer.sv
module tcs_conv_timer #(
  parameter int CONV_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic hold,
  output logic busy,
  output logic done
);
  localparam int CNT_W = $clog2(CONV_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(CONV_CYCLES - 1);

  logic             busy_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;

  always_comb begin
    done   = busy && (cnt_q == '0) && hold;
    busy_n = busy;
    cnt_n  = cnt_q;
    if (go) begin
      busy_n = 1'b1;
      cnt_n  = LOAD;
    end else if (!hold || done) begin
      busy_n = 1'b0;
    end else if (busy && (cnt_q != '0)) begin
      cnt_n = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else begin
      busy  <= busy_n;
      cnt_q <= cnt_n;
    end
  end
endmodule

// File: rtl/tcs_dav_flags.sv
module tcs_dav_flags
  import tcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic [DATA_W-1:0] set_mask,
  input  logic [DATA_W-1:0] clr,
  output logic [DATA_W-1:0] dav_q,
  output logic              irq_n
);
  logic [DATA_W-1:0] dav_n;
  logic              irq_n_n;

  always_comb begin
    dav_n   = (dav_q & ~clr) | (done ? set_mask : '0);
    irq_n_n = irq_n;
    if (done)              irq_n_n = 1'b0;
    else if (dav_n == '0)  irq_n_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dav_q <= '0;
      irq_n <= 1'b1;
    end else begin
      dav_q <= dav_n;
      irq_n <= irq_n_n;
    end
  end
endmodule

// File: rtl/tcs_pen_irq.sv
module tcs_pen_irq
  import tcs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_we,
  input  logic [1:0] sel_in,
  input  logic       pen,
  input  logic       any_dav,
  input  logic       en,
  output logic       irq_n
);
  pin_fn_e sel_q, sel_n;
  logic    active;

  always_comb begin
    sel_n = sel_we ? pin_fn_e'(sel_in) : sel_q;
    case (sel_q)
      PIN_PRESS:    active = pen;
      PIN_ANY_DATA: active = any_dav;
      default:      active = pen & ~any_dav;
    endcase
    active = active & en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= PIN_PRESS_CLEAR;
      irq_n <= 1'b1;
    end else begin
      sel_q <= sel_n;
      irq_n <= ~active;
    end
  end
endmodule

// File: rtl/touch_conv_sched.sv
module touch_conv_sched
  import tcs_pkg::*;
#(
  parameter int CLK_HZ       = 250_000_000,
  parameter int CONV_RATE_HZ = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [DATA_W-1:0] ctrl_wdata,
  input  logic              pen_fn_we,
  input  logic [1:0]        pen_fn_sel,
  input  logic              pen_down,
  input  logic [DATA_W-1:0] rd_strobe,
  input  logic [DATA_W-1:0] raw_in,
  output logic              busy,
  output logic [DATA_W-1:0] dav_flags,
  output logic [DATA_W-1:0] result_out,
  output logic              pen_irq_n,
  output logic              dav_irq_n
);
  localparam int CONV_CYCLES = (CLK_HZ / CONV_RATE_HZ < 1) ? 1 : CLK_HZ / CONV_RATE_HZ;

  logic             en_q, en_v, kill, en_ok, go, done, pen_gate;
  logic [FN_W-1:0]  nf_v, act_fn_q, act_fn_n;
  logic [RES_W-1:0] nr_v, act_res_q, act_res_n;

  tcs_ctrl_regs u_ctrl (
    .clk(clk), .rst_n(rst_n), .we(ctrl_we), .wdata(ctrl_wdata), .kill(kill),
    .en_q(en_q), .en_v(en_v), .nf_v(nf_v), .nr_v(nr_v)
  );

  // Start and single-shot disable decisions
  always_comb begin
    pen_gate = wants_pen(nf_v) ? pen_down : 1'b1;
    kill     = one_shot(nf_v) && pen_gate && (dav_flags != '0);
    en_ok    = en_v && !kill;
    go       = en_ok && !busy && (dav_flags == '0) && !idle_fn(nf_v) && pen_gate;
    act_fn_n  = go ? nf_v : act_fn_q;
    act_res_n = go ? nr_v : act_res_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_fn_q  <= '0;
      act_res_q <= '0;
    end else begin
      act_fn_q  <= act_fn_n;
      act_res_q <= act_res_n;
    end
  end

  tcs_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .go(go), .hold(en_ok), .busy(busy), .done(done)
  );

  tcs_dav_flags u_dav (
    .clk(clk), .rst_n(rst_n), .done(done), .set_mask(done_mask(act_fn_q)),
    .clr(rd_strobe), .dav_q(dav_flags), .irq_n(dav_irq_n)
  );

  tcs_pen_irq u_pen (
    .clk(clk), .rst_n(rst_n), .sel_we(pen_fn_we), .sel_in(pen_fn_sel),
    .pen(pen_down), .any_dav(|dav_flags), .en(en_q), .irq_n(pen_irq_n)
  );

  assign result_out = raw_in >> trunc_shift(act_res_q);
endmodule

// File: rtl/tcs_checker.sv
module tcs_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic [15:0] dav,
  input logic        dav_irq_n,
  input logic        pen_irq_n,
  input logic [15:0] rd_strobe,
  input logic        ctrl_we,
  input logic [15:0] ctrl_wdata,
  input logic        en_q
);
  p_busy_no_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (dav == 16'h0));

  p_start_needs_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(dav) == 16'h0));

  p_bits_only_at_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> ((dav & ~$past(dav)) == 16'h0));

  p_irq_falls_at_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dav_irq_n) |-> $past(busy));

  p_cancel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && ctrl_wdata[14]) |=> !busy);

  p_pen_off_when_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> pen_irq_n);

  for (genvar k = 0; k < 16; k++) begin : g_clr
    p_strobe_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_strobe[k] && !busy) |=> !dav[k]);
  end
endmodule

bind touch_conv_sched tcs_checker i_tcs_checker (
  .clk(clk), .rst_n(rst_n), .busy(busy), .dav(dav_flags), .dav_irq_n(dav_irq_n),
  .pen_irq_n(pen_irq_n), .rd_strobe(rd_strobe), .ctrl_we(ctrl_we),
  .ctrl_wdata(ctrl_wdata), .en_q(en_q)
);

// File: tb/test_touch_conv_sched.sv
`timescale 1ns/1ps
module test_touch_conv_sched;
  localparam int CONV = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctrl_we;
  logic [15:0] ctrl_wdata;
  logic        pen_fn_we;
  logic [1:0]  pen_fn_sel;
  logic        pen_down;
  logic [15:0] rd_strobe;
  logic [15:0] raw_in;
  logic        busy;
  logic [15:0] dav_flags;
  logic [15:0] result_out;
  logic        pen_irq_n;
  logic        dav_irq_n;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  touch_conv_sched #(.CLK_HZ(16384), .CONV_RATE_HZ(1024)) i_touch_conv_sched (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .pen_fn_we(pen_fn_we), .pen_fn_sel(pen_fn_sel), .pen_down(pen_down),
    .rd_strobe(rd_strobe), .raw_in(raw_in), .busy(busy), .dav_flags(dav_flags),
    .result_out(result_out), .pen_irq_n(pen_irq_n), .dav_irq_n(dav_irq_n)
  );

  function automatic logic [15:0] exp_mask(input int f);
    case (f)
      1: return 16'h0600;  2: return 16'h0780;  3: return 16'h0400;
      4: return 16'h0200;  5: return 16'h0180;  6: return 16'h0040;
      7: return 16'h0030;  8: return 16'h0010;  9: return 16'h0010;
      10: return 16'h0004; 11: return 16'h0070; 12: return 16'h0002;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic bit exp_start(input int f, input bit p);
    if (f == 0 || f >= 13) return 1'b0;
    if (f <= 5) return p;
    return 1'b1;
  endfunction

  function automatic bit exp_off(input int f, input bit p);
    if (f >= 3 && f <= 5) return p;
    return (f >= 6 && f <= 8) || f == 10 || f == 12;
  endfunction

  function automatic int exp_shift(input int r);
    return (r == 1) ? 8 : (r == 2) ? 6 : 4;
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [15:0] v);
    @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
    @(negedge clk); ctrl_we = 1'b0;
  endtask

  task automatic strobe(input logic [15:0] m);
    @(negedge clk); rd_strobe = m;
    @(negedge clk); rd_strobe = '0;
  endtask

  task automatic set_pin(input logic [1:0] c);
    @(negedge clk); pen_fn_we = 1'b1; pen_fn_sel = c;
    @(negedge clk); pen_fn_we = 1'b0;
  endtask

  function automatic logic [15:0] cw(input bit dis, input int f, input int r);
    return {1'b1, dis, 4'(f), 2'(r), 8'h5A};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int bcnt;
    rst_n = 1'b0; ctrl_we = 1'b0; ctrl_wdata = '0; pen_fn_we = 1'b0;
    pen_fn_sel = '0; pen_down = 1'b0; rd_strobe = '0; raw_in = '0;
    repeat (3) @(negedge clk);
    check("R1 busy", {15'h0, busy}, 16'h0);
    check("R1 dav", dav_flags, 16'h0);
    check("R1 dav_irq_n", {15'h0, dav_irq_n}, 16'h1);
    check("R1 pen_irq_n", {15'h0, pen_irq_n}, 16'h1);
    rst_n = 1'b1;
    // disabled after reset: pen does nothing
    pen_down = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 disabled pen_irq_n", {15'h0, pen_irq_n}, 16'h1);
    // enable with code 0 (never starts); default pin code 2 -> pen & no data
    wr_ctrl(cw(1'b0, 0, 0));
    repeat (2) @(negedge clk);
    check("R1 default pin code", {15'h0, pen_irq_n}, 16'h0);
    check("R3 code 0 no start", {15'h0, busy}, 16'h0);
    wr_ctrl(cw(1'b1, 0, 0));

    // sweep every function code with and without pen (R2..R5, R7, R10)
    for (int f = 0; f < 16; f++) begin
      for (int p = 0; p < 2; p++) begin
        bit st, off;
        st  = exp_start(f, p[0]);
        off = exp_off(f, p[0]);
        @(negedge clk);
        pen_down = p[0];
        raw_in = 16'h9C3B + 16'(f * 16'h1111);
        wr_ctrl(cw(1'b0, f, f % 4));
        bcnt = 0;
        repeat (40) begin
          if (busy) bcnt++;
          @(negedge clk);
        end
        check($sformatf("R3/R4 busy cycles f=%0d p=%0d", f, p), 16'(bcnt), st ? 16'(CONV) : 16'h0);
        check($sformatf("R5 mask f=%0d p=%0d", f, p), dav_flags, st ? exp_mask(f) : 16'h0);
        check($sformatf("R4 dav_irq_n f=%0d p=%0d", f, p), {15'h0, dav_irq_n}, {15'h0, !st});
        if (st)
          check($sformatf("R10 result f=%0d", f), result_out, raw_in >> exp_shift(f % 4));
        strobe(16'hFFFF);
        check($sformatf("R6 cleared f=%0d p=%0d", f, p), dav_flags, 16'h0);
        check($sformatf("R6 irq released f=%0d p=%0d", f, p), {15'h0, dav_irq_n}, 16'h1);
        @(negedge clk);
        check($sformatf("R7 restart f=%0d p=%0d", f, p), {15'h0, busy}, {15'h0, st && !off});
        wr_ctrl(cw(1'b1, f, f % 4));
        strobe(16'hFFFF);
        @(negedge clk);
      end
    end

    // R6 selective clearing
    pen_down = 1'b1;
    wr_ctrl(cw(1'b0, 2, 0));
    repeat (20) @(negedge clk);
    check("R6 setup mask", dav_flags, 16'h0780);
    strobe(16'h0400);
    check("R6 single bit clear", dav_flags, 16'h0380);
    check("R6 irq still low", {15'h0, dav_irq_n}, 16'h0);
    strobe(16'h0001);
    check("R6 strobe on clear bit ignored", dav_flags, 16'h0380);
    strobe(16'h0380);
    check("R6 all clear", dav_flags, 16'h0);
    check("R6 irq high", {15'h0, dav_irq_n}, 16'h1);
    wr_ctrl(cw(1'b1, 0, 0));
    strobe(16'hFFFF);

    // R8 cancel
    pen_down = 1'b0;
    wr_ctrl(cw(1'b0, 6, 0));
    repeat (5) @(negedge clk);
    check("R8 running", {15'h0, busy}, 16'h1);
    wr_ctrl(cw(1'b1, 6, 0));
    check("R8 busy cleared", {15'h0, busy}, 16'h0);
    repeat (30) @(negedge clk);
    check("R8 no data", dav_flags, 16'h0);
    check("R8 no irq", {15'h0, dav_irq_n}, 16'h1);

    // R10 latched resolution
    wr_ctrl(cw(1'b0, 9, 1));
    repeat (20) @(negedge clk);
    for (int v = 0; v < 4; v++) begin
      raw_in = 16'hFFFF - 16'(v * 16'h3579);
      #1;
      check("R10 res 8 bit", result_out, raw_in >> 8);
    end
    wr_ctrl(cw(1'b1, 9, 2));
    check("R10 next res not applied", result_out, raw_in >> 8);
    strobe(16'hFFFF);
    wr_ctrl(cw(1'b0, 9, 2));
    repeat (20) @(negedge clk);
    check("R10 res 10 bit", result_out, raw_in >> 6);
    wr_ctrl(cw(1'b1, 0, 0));
    strobe(16'hFFFF);

    // R9 pen-interrupt truth table: data pending, then none
    pen_down = 1'b0;
    wr_ctrl(cw(1'b0, 9, 0));
    repeat (20) @(negedge clk);
    wr_ctrl(cw(1'b0, 0, 0));
    for (int d = 1; d >= 0; d--) begin
      if (d == 0) strobe(16'hFFFF);
      for (int c = 0; c < 4; c++) begin
        set_pin(2'(c));
        for (int p = 0; p < 2; p++) begin
          bit act;
          pen_down = p[0];
          repeat (2) @(negedge clk);
          act = (c == 0) ? p[0] : (c == 1) ? d[0] : (p[0] && !d[0]);
          check($sformatf("R9 pin c=%0d p=%0d d=%0d", c, p, d), {15'h0, pen_irq_n}, {15'h0, !act});
        end
      end
    end
    set_pin(2'd0);
    pen_down = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 enabled pressure", {15'h0, pen_irq_n}, 16'h0);
    wr_ctrl(cw(1'b1, 0, 0));
    repeat (2) @(negedge clk);
    check("R9 forced high when disabled", {15'h0, pen_irq_n}, 16'h1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule